// File: doc/BRIEF.md
# 8B/10B Line Encoder with Per-Word Disparity Override

This block maps each accepted byte, together with a control flag, onto a 10-bit transmission code group. It builds the group from a 5-bit to 6-bit sub-block and a 3-bit to 4-bit sub-block. It keeps a running disparity, so the serial stream it feeds stays DC-balanced. When the control flag is set and the byte names one of the twelve legal special characters, the encoder emits that special code group. When the control flag is set for any other byte, the encoder flags the request and encodes the byte as ordinary data.

A per-word override lets the transmit logic pick the starting disparity of the current group, in place of the tracked value. This is useful for aligning a stream to a required polarity, for example at the start of an ordered set. Tracking then carries on from the disparity that the overridden group leaves behind. A valid strobe qualifies each input word. The results are registered and appear one clock after the word is accepted.

Top module: `lc_enc8b10b`

## Requirements
- R1: While reset is asserted and after its release, before any word is accepted: `out_valid`=0, `out_code`=0, `out_kerr`=0 and `out_rd`=0. The value 0 on `out_rd` means negative running disparity.
- R2: A word presented with `in_valid`=1 on a rising edge produces its code group, error flag and new disparity on the outputs after that same edge, with `out_valid`=1 for that one cycle.
- R3: Code group layout: `out_code[9:4]` carries the 6-bit sub-block abcdei, with a at bit 9. `out_code[3:0]` carries fghj, with f at bit 3. The 5-bit part is `in_byte[4:0]` and the 3-bit part is `in_byte[7:5]`. Data groups follow the standard tables; for example, D21.5 is 0x2AA from either disparity.
- R4: Every emitted code group contains 4, 5 or 6 ones.
- R5: `out_rd` (1 = positive) is the disparity after the emitted group. A group with 6 ones makes it 1, a group with 4 ones makes it 0, and a group with 5 ones leaves the starting disparity unchanged.
- R6: With `in_ctrl`=1, the bytes K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 emit special groups. K28.5 is 0x0FA from negative disparity and 0x305 from positive.
- R7: With `in_ctrl`=1 and any other byte, `out_kerr`=1 and the byte is encoded as data. `out_kerr`=0 for every word with `in_ctrl`=0 or a legal special byte.
- R8: With `force_en`=1, the group is encoded from the disparity given by `force_rd` (1 = positive) instead of the tracked one. Later words track from that group's result.
- R9: A cycle with `in_valid`=0 gives `out_valid`=0 on the next edge. `out_code`, `out_kerr` and `out_rd` hold their values, whatever the other inputs do.
- R10: Data with 3-bit value 7 uses the alternate 4-bit form for x=17, 18 or 20 when the 6-bit sub-block leaves negative disparity, and for x=11, 13 or 14 when it leaves positive disparity. D17.7 from negative disparity is 0x237.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input word |
| in_byte | input | 8 | Byte to encode |
| in_ctrl | input | 1 | Request a special (control) group |
| force_en | input | 1 | Override the starting disparity for this word |
| force_rd | input | 1 | Override disparity, 1 = positive |
| out_valid | output | 1 | A new code group is present |
| out_code | output | 10 | Code group, a at bit 9 and j at bit 0 |
| out_rd | output | 1 | Running disparity after the last group, 1 = positive |
| out_kerr | output | 1 | The last word requested an illegal special character |

## Verification
The bench targets four kinds of word, each of which a faulty design would show plainly:
- Neutral groups that must not flip disparity, such as D21.5 and D0.0. A bad flip rule would swap the polarity of every later group.
- The alternate-7 data cases and D7.y / Dx.3, whose neutral sub-blocks still change form with disparity. A wrong selection here emits runs of five equal bits.
- K28 groups with neutral 3-bit values, which use the opposite polarity from data. An error here corrupts comma characters.
- Forced disparity followed by free-running words, which shows whether tracking resumes from the forced group. A dropped `in_valid` qualifier would show up as disparity drifting during idle cycles.

// File: rtl/lc_enc_pkg.sv
package lc_enc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = 3;
  localparam int unsigned SIX_W  = 6;
  localparam int unsigned FOUR_W = 4;
  localparam int unsigned CODE_W = SIX_W + FOUR_W;
  localparam logic [LO_W-1:0] K28_LO = 5'd28;
  localparam logic [HI_W-1:0] HI_ALT = 3'd7;

  typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;
endpackage

// File: rtl/lc_kchar_sel.sv
module lc_kchar_sel
  import lc_enc_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctrl_i,
  output logic              is_k_o,
  output logic              is_k28_o,
  output logic              kerr_o
);
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic            legal;
  logic            lone7;

  always_comb begin
    lo    = byte_i[LO_W-1:0];
    hi    = byte_i[BYTE_W-1:LO_W];
    lone7 = (hi == HI_ALT) &&
            ((lo == 5'd23) || (lo == 5'd27) || (lo == 5'd29) || (lo == 5'd30));
    legal    = (lo == K28_LO) || lone7;
    is_k_o   = ctrl_i && legal;
    is_k28_o = ctrl_i && (lo == K28_LO);
    kerr_o   = ctrl_i && !legal;
  end
endmodule

// File: rtl/lc_sub6.sv
module lc_sub6
  import lc_enc_pkg::*;
(
  input  logic [LO_W-1:0]  lo_i,
  input  logic             k28_i,
  input  logic             rd_i,
  output logic [SIX_W-1:0] code_o,
  output logic             rd_o
);
  logic [SIX_W-1:0] base;
  logic             invert;
  int unsigned      ones;

  always_comb begin
    unique case (lo_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = k28_i ? 6'b001111 : 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    invert = rd_i && (($countones(base) != 3) || (lo_i == 5'd7));
    code_o = invert ? ~base : base;
    ones   = $countones(code_o);
    if (ones > 3)      rd_o = 1'b1;
    else if (ones < 3) rd_o = 1'b0;
    else               rd_o = rd_i;
  end
endmodule

// File: rtl/lc_sub4.sv
module lc_sub4
  import lc_enc_pkg::*;
(
  input  logic [HI_W-1:0]   hi_i,
  input  logic              k28_i,
  input  logic              alt_i,
  input  logic              rd_i,
  output logic [FOUR_W-1:0] code_o,
  output logic              rd_o
);
  logic [FOUR_W-1:0] base;
  logic              neutral;
  int unsigned       ones;

  always_comb begin
    unique case (hi_i)
      3'd0:    base = 4'b1011;
      3'd1:    base = 4'b1001;
      3'd2:    base = 4'b0101;
      3'd3:    base = 4'b1100;
      3'd4:    base = 4'b1101;
      3'd5:    base = 4'b1010;
      3'd6:    base = 4'b0110;
      default: base = alt_i ? 4'b0111 : 4'b1110;
    endcase
    neutral = ($countones(base) == 2) && (hi_i != 3'd3);
    if (k28_i && neutral)
      code_o = rd_i ? base : ~base;
    else if (rd_i && !neutral)
      code_o = ~base;
    else
      code_o = base;
    ones = $countones(code_o);
    if (ones > 2)      rd_o = 1'b1;
    else if (ones < 2) rd_o = 1'b0;
    else               rd_o = rd_i;
  end
endmodule

// File: rtl/lc_enc8b10b.sv
module lc_enc8b10b
  import lc_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_ctrl,
  input  logic              force_en,
  input  logic              force_rd,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_rd,
  output logic              out_kerr
);
  logic              is_k, is_k28, kerr;
  logic              rd_start, rd_mid, rd_end;
  logic              use_alt;
  logic [LO_W-1:0]   lo;
  logic [HI_W-1:0]   hi;
  logic [SIX_W-1:0]  six;
  logic [FOUR_W-1:0] four;

  logic              vld_q, vld_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              rd_q, rd_d;
  logic              kerr_q, kerr_d;

  assign lo = in_byte[LO_W-1:0];
  assign hi = in_byte[BYTE_W-1:LO_W];

  lc_kchar_sel u_ksel (
    .byte_i  (in_byte),
    .ctrl_i  (in_ctrl),
    .is_k_o  (is_k),
    .is_k28_o(is_k28),
    .kerr_o  (kerr)
  );

  always_comb rd_start = force_en ? force_rd : rd_q;

  lc_sub6 u_six (
    .lo_i  (lo),
    .k28_i (is_k28),
    .rd_i  (rd_start),
    .code_o(six),
    .rd_o  (rd_mid)
  );

  always_comb begin
    use_alt = 1'b0;
    if (hi == HI_ALT) begin
      if (is_k)
        use_alt = 1'b1;
      else if (!rd_mid)
        use_alt = (lo == 5'd17) || (lo == 5'd18) || (lo == 5'd20);
      else
        use_alt = (lo == 5'd11) || (lo == 5'd13) || (lo == 5'd14);
    end
  end

  lc_sub4 u_four (
    .hi_i  (hi),
    .k28_i (is_k28),
    .alt_i (use_alt),
    .rd_i  (rd_mid),
    .code_o(four),
    .rd_o  (rd_end)
  );

  always_comb begin
    vld_d  = in_valid;
    code_d = code_q;
    rd_d   = rd_q;
    kerr_d = kerr_q;
    if (in_valid) begin
      code_d = {six, four};
      rd_d   = rd_end;
      kerr_d = kerr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      rd_q   <= RD_NEG;
      kerr_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        code_q <= code_d;
        rd_q   <= rd_d;
        kerr_q <= kerr_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_code  = code_q;
  assign out_rd    = rd_q;
  assign out_kerr  = kerr_q;
endmodule

// File: rtl/lc_enc8b10b_chk.sv
module lc_enc8b10b_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       in_ctrl,
  input logic       out_valid,
  input logic [9:0] out_code,
  input logic       out_rd,
  input logic       out_kerr
);
  // R4: every emitted group is near-balanced
  assert_balanced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_code) >= 4 && $countones(out_code) <= 6));

  // R5: heavy group leaves positive disparity
  assert_rd_heavy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $countones(out_code) == 6) |-> out_rd);

  // R5: light group leaves negative disparity
  assert_rd_light_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $countones(out_code) == 4) |-> !out_rd);

  // R2: an accepted word yields a valid output next cycle
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: idle cycles hold the state
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_rd) && $stable(out_code) && $stable(out_kerr)));

  // R7: data words never raise the control error
  assert_no_kerr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ctrl) |=> !out_kerr);
endmodule

bind lc_enc8b10b lc_enc8b10b_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_byte  (in_byte),
  .in_ctrl  (in_ctrl),
  .out_valid(out_valid),
  .out_code (out_code),
  .out_rd   (out_rd),
  .out_kerr (out_kerr)
);

// File: tb/lc_enc8b10b_test.sv
`timescale 1ns/1ps
module lc_enc8b10b_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ctrl, force_en, force_rd;
  logic [7:0] in_byte;
  logic       out_valid, out_rd, out_kerr;
  logic [9:0] out_code;

  int n_chk = 0;
  int n_bad = 0;
  logic m_rd;

  always #5 clk = ~clk;

  lc_enc8b10b uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ctrl(in_ctrl), .force_en(force_en), .force_rd(force_rd),
    .out_valid(out_valid), .out_code(out_code), .out_rd(out_rd), .out_kerr(out_kerr)
  );

  function automatic logic [5:0] m6(input logic [4:0] x, input logic k);
    logic [5:0] t [32] = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,
      6'b011001,6'b111000,6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,
      6'b011100,6'b010111,6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,
      6'b011010,6'b111010,6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,
      6'b011110,6'b101011};
    if (k && x == 5'd28) return 6'b001111;
    return t[x];
  endfunction

  function automatic logic is_legal_k(input logic [7:0] b);
    return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) || (b == 8'hFD) || (b == 8'hFE);
  endfunction

  // reference: {kerr, rd_after, code}
  function automatic logic [11:0] ref_enc(input logic [7:0] b, input logic c, input logic rd);
    logic k, k28, rd1, alt;
    logic [5:0] s;
    logic [3:0] f, fneg;
    logic [4:0] x;
    logic [2:0] y;
    int n;
    x = b[4:0]; y = b[7:5];
    k = c && is_legal_k(b);
    k28 = k && (x == 5'd28);
    s = m6(x, k);
    if (rd && ($countones(s) != 3 || x == 5'd7)) s = ~s;
    n = $countones(s);
    rd1 = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : rd;
    alt = (y == 3'd7) && (k || (!rd1 && (x==17 || x==18 || x==20)) ||
                               (rd1 && (x==11 || x==13 || x==14)));
    case (y)
      3'd0: fneg = 4'b1011; 3'd1: fneg = k28 ? 4'b0110 : 4'b1001;
      3'd2: fneg = k28 ? 4'b1010 : 4'b0101; 3'd3: fneg = 4'b1100;
      3'd4: fneg = 4'b1101; 3'd5: fneg = k28 ? 4'b0101 : 4'b1010;
      3'd6: fneg = k28 ? 4'b1001 : 4'b0110; default: fneg = alt ? 4'b0111 : 4'b1110;
    endcase
    if (!rd1) f = fneg;
    else if ($countones(fneg) != 2 || y == 3'd3 || k28) f = ~fneg;
    else f = fneg;
    n = $countones({s, f});
    return {c && !k, (n > 5) ? 1'b1 : (n < 5) ? 1'b0 : rd, s, f};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drive one word, check after the edge
  task automatic send(input logic [7:0] b, input logic c, input logic fe, input logic fr,
                      input string rq);
    logic [11:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_ctrl = c; force_en = fe; force_rd = fr;
    e = ref_enc(b, c, fe ? fr : m_rd);
    @(posedge clk); #1;
    chk(rq, {31'd0, out_valid}, 32'd1);
    chk(rq, {22'd0, out_code}, {22'd0, e[9:0]});
    chk(rq, {31'd0, out_rd}, {31'd0, e[10]});
    chk(rq, {31'd0, out_kerr}, {31'd0, e[11]});
    m_rd = e[10];
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] hc; logic hr, hk;
    rst_n = 1'b0; in_valid = 0; in_byte = 0; in_ctrl = 0; force_en = 0; force_rd = 0;
    m_rd = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {29'd0, out_valid, out_kerr, out_rd}, 32'd0);
    chk("R1", {22'd0, out_code}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", {29'd0, out_valid, out_kerr, out_rd}, 32'd0);

    // R6: comma from both polarities
    send(8'hBC, 1, 0, 0, "R6");
    chk("R6 K28.5 neg", {22'd0, out_code}, 32'h0FA);
    send(8'hBC, 1, 0, 0, "R6");
    chk("R6 K28.5 pos", {22'd0, out_code}, 32'h305);
    // R3/R5: neutral D21.5 keeps disparity
    send(8'hB5, 0, 0, 0, "R3");
    chk("R3 D21.5", {22'd0, out_code}, 32'h2AA);
    chk("R5 neutral", {31'd0, out_rd}, 32'd0);
    // R10: D17.7 from negative
    send(8'hF1, 0, 0, 0, "R10");
    chk("R10 D17.7", {22'd0, out_code}, 32'h237);
    send(8'hEB, 0, 0, 0, "R10"); send(8'hF4, 0, 0, 0, "R10");
    send(8'h07, 0, 0, 0, "R3"); send(8'h63, 0, 0, 0, "R3");
    // R7: illegal special request encoded as data
    send(8'h00, 1, 0, 0, "R7");
    chk("R7 kerr", {31'd0, out_kerr}, 32'd1);
    send(8'hF7, 1, 0, 0, "R6"); send(8'h3C, 1, 0, 0, "R6"); send(8'hFC, 1, 0, 0, "R6");
    // R8: forced polarity then free tracking
    send(8'hBC, 1, 1, 1, "R8");
    chk("R8 forced pos", {22'd0, out_code}, 32'h305);
    send(8'h1C, 1, 0, 0, "R8");
    send(8'hBC, 1, 1, 0, "R8");
    chk("R8 forced neg", {22'd0, out_code}, 32'h0FA);
    // R9: idle cycle holds everything
    hc = out_code; hr = out_rd; hk = out_kerr;
    @(negedge clk); in_valid = 0; in_byte = 8'hBC; in_ctrl = 1; force_en = 1; force_rd = ~hr;
    @(posedge clk); #1;
    chk("R9 valid", {31'd0, out_valid}, 32'd0);
    chk("R9 hold", {20'd0, out_code, out_rd, out_kerr}, {20'd0, hc, hr, hk});

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b; logic c, fe, fr;
      b  = 8'($urandom);
      c  = ($urandom % 6) == 0;
      if (c && ($urandom % 2)) b = (($urandom % 3) == 0) ? 8'hFB : {3'($urandom), 5'd28};
      fe = ($urandom % 10) == 0;
      fr = 1'($urandom);
      if (($urandom % 8) == 0) begin
        hc = out_code; hr = out_rd; hk = out_kerr;
        @(negedge clk); in_valid = 0; in_byte = b; in_ctrl = c; force_en = fe; force_rd = fr;
        @(posedge clk); #1;
        chk("R9", {19'd0, out_valid, out_code, out_rd, out_kerr}, {20'd0, hc, hr, hk});
      end else begin
        send(b, c, fe, fr, c ? "R6/R7" : "R3/R5");
        chk("R4", 32'($countones(out_code) >= 4 && $countones(out_code) <= 6), 32'd1);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule